// File: doc/BRIEF.md
# I2C Addressed Register-File Target

This block is an I2C target that holds a small bank of byte registers and serves register-read transactions on the bus. A master starts a transaction, sends a 7-bit target address and a direction bit, then sends one register-index byte. The addressed target acknowledges both bytes. It then returns the indexed register's byte at once, with no repeated start in between. After that byte the target lets go of SDA, takes in the master's acknowledge bit, and stays silent until the next stop or start.

The target pulls SDA low and never drives it high. Several copies with different address parameters can therefore hang on the same SCL/SDA pair, and the pull-up resolves the wire as a wired-AND. A target whose address does not match keeps its SDA driver off for the whole transaction. SCL and SDA are brought into the system clock domain through synchroniser flops. Each register holds a fixed value computed from two parameters, so every copy can carry distinct contents.

Top module: `i2c_regfile_target`

## Requirements
- R1: While reset is asserted and right after it, `sda_pull_o` is 0 (SDA released), and the target waits for a start condition.
- R2: After a start, the target samples 8 bits on rising SCL edges, MSB first: 7 address bits, then the direction bit. If the 7 address bits equal `TGT_ADDR`, the target pulls SDA low for the whole ninth clock. Otherwise SDA stays released.
- R3: The value of the direction bit (0 or 1) has no effect on address matching or on the rest of the transaction.
- R4: After an acknowledged address, the target samples one index byte, MSB first, and pulls SDA low for its ninth clock.
- R5: Next the target drives 8 data bits, MSB first, one per SCL clock, changing SDA only on falling edges. A 0 bit pulls SDA low and a 1 bit releases it. The byte is the register at `index mod NUM_REGS`, whose value is `(k*REG_STEP + REG_SEED) mod 256` for register k.
- R6: After the data byte, the target releases SDA for the master's acknowledge clock, whether that bit is 0 or 1. It keeps SDA released on any further SCL clocks until a start or stop.
- R7: On an address mismatch, the target never pulls SDA until the next start condition. The bus reads 1 for every acknowledge and data bit.
- R8: Two targets with different addresses on one bus never pull SDA at the same time, and each answers only its own address.
- R9: A start condition (SDA falling while SCL is high) seen in any state clears the bit counter and restarts address reception.
- R10: A stop condition (SDA rising while SCL is high) seen in any state releases SDA and returns the target to address reception. A transaction that follows is served normally.
- R11: `sda_pull_o` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus (wired-AND of all drivers) |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it to the pull-up |

## Verification
The hardest situations to reach are a start or stop arriving in the middle of a byte, and two targets sharing one wire. The bench models the wire as a wired-AND of the master and two target copies. It sweeps all 128 addresses and checks that only the two configured ones ever pull the acknowledge low. It reads 32 indices from one target and 16 from the other, with expected bytes computed arithmetically. It also cuts transactions short with a stop after a few index bits and with a repeated start after the address acknowledge. In each case the next transaction must come back correct.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared state encoding for the I2C register-file target.
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start condition, SDA released
        ST_ADDR,   // shifting in address and direction bit
        ST_AACK,   // acknowledging the address
        ST_IDX,    // shifting in the register index
        ST_IACK,   // acknowledging the index
        ST_DATA,   // driving the register byte
        ST_MACK,   // released, master's acknowledge clock
        ST_WAIT    // released, waiting for stop or start
    } tgt_state_t;

endpackage

// File: rtl/i2c_bus_sync.sv
// Bus synchroniser: brings SCL and SDA into the clk domain and detects
// SCL edges plus start and stop conditions on the synchronised levels.
// Assumes both lines idle high; reset values are therefore 1.
module i2c_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_prev;
    logic                   sda_prev;

    // Synchroniser chains plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
            scl_prev  <= scl_chain[SYNC_STAGES-1];
            sda_prev  <= sda_chain[SYNC_STAGES-1];
        end
    end

    // Edge and bus-condition decode from current and previous levels.
    always_comb begin
        scl_s     = scl_chain[SYNC_STAGES-1];
        sda_s     = sda_chain[SYNC_STAGES-1];
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        start_evt = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_evt  = scl_s & scl_prev & ~sda_prev & sda_s;
    end

endmodule

// File: rtl/i2c_tgt_regbank.sv
// Register bank: NUM_REGS fixed bytes, value of entry k is
// (k*REG_STEP + REG_SEED) mod 256. Read is combinational by index.
// Assumes NUM_REGS is a power of two so every index value is valid.
module i2c_tgt_regbank #(
    parameter int NUM_REGS = 16,
    parameter int REG_STEP = 37,
    parameter int REG_SEED = 90,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);

    logic [7:0] bank [NUM_REGS];

    // One constant byte per entry, computed from the parameters.
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_entry
        assign bank[k] = 8'((k * REG_STEP + REG_SEED) % 256);
    end

    // Indexed read.
    assign rd_byte = bank[rd_idx];

endmodule

// File: rtl/i2c_tgt_fsm.sv
// Transaction sequencer: address match, index capture, data return.
// Samples SDA on synchronised SCL rising edges and changes its pull only
// on falling edges. Start and stop override every state.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'h2A,
    parameter int         IDX_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic [7:0]       rd_byte,
    output logic [IDX_W-1:0] rd_idx,
    output logic             sda_pull,
    output tgt_state_t       state,
    output logic [2:0]       bit_cnt
);

    logic [6:0] shift_in;
    logic [6:0] shift_out;
    logic [7:0] in_byte;

    // Byte completed by the bit sampled on this rising edge.
    assign in_byte = {shift_in, sda_s};

    // Main sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            shift_in  <= '0;
            shift_out <= '0;
            rd_idx    <= '0;
            sda_pull  <= 1'b0;
        end else if (start_evt || stop_evt) begin
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_IDX: begin
                    if (scl_rise) begin
                        shift_in <= in_byte[6:0];
                        bit_cnt  <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            if (state == ST_IDX) begin
                                rd_idx <= in_byte[IDX_W-1:0];
                                state  <= ST_IACK;
                            end else if (shift_in == TGT_ADDR) begin
                                state <= ST_AACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        if (!sda_pull) begin
                            sda_pull <= 1'b1;
                        end else begin
                            sda_pull <= 1'b0;
                            bit_cnt  <= '0;
                            state    <= ST_IDX;
                        end
                    end
                end
                ST_IACK: begin
                    if (scl_fall) begin
                        if (!sda_pull) begin
                            sda_pull <= 1'b1;
                        end else begin
                            sda_pull  <= ~rd_byte[7];
                            shift_out <= rd_byte[6:0];
                            bit_cnt   <= '0;
                            state     <= ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == 3'd7) begin
                            sda_pull <= 1'b0;
                            state    <= ST_MACK;
                        end else begin
                            sda_pull  <= ~shift_out[6];
                            shift_out <= {shift_out[5:0], 1'b0};
                            bit_cnt   <= bit_cnt + 3'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        state <= ST_WAIT;
                    end
                end
                default: begin
                    sda_pull <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_regfile_target.sv
// I2C register-file target top: synchroniser, sequencer and register bank.
// Drives SDA only as an open-drain pull; the bus is assumed to be a
// wired-AND through an external pull-up.
module i2c_regfile_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR    = 7'h2A,
    parameter int         NUM_REGS    = 16,
    parameter int         REG_STEP    = 37,
    parameter int         REG_SEED    = 90,
    parameter int         SYNC_STAGES = 2,
    localparam int        IDX_W       = $clog2(NUM_REGS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);

    logic             scl_sync;
    logic             sda_sync;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_evt;
    logic             stop_evt;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_byte;
    tgt_state_t       state;
    logic [2:0]       bit_cnt;

    i2c_bus_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_sync),
        .sda_s     (sda_sync),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_tgt_fsm #(
        .TGT_ADDR (TGT_ADDR),
        .IDX_W    (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_sync),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .rd_byte   (rd_byte),
        .rd_idx    (rd_idx),
        .sda_pull  (sda_pull_o),
        .state     (state),
        .bit_cnt   (bit_cnt)
    );

    i2c_tgt_regbank #(
        .NUM_REGS (NUM_REGS),
        .REG_STEP (REG_STEP),
        .REG_SEED (REG_SEED)
    ) u_bank (
        .rd_idx  (rd_idx),
        .rd_byte (rd_byte)
    );

endmodule

// File: rtl/i2c_regfile_target_chk.sv
// Checker for the I2C register-file target, bound into every instance.
// Observes the pull output against synchronised SCL, bus events and state.
module i2c_regfile_target_chk
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sda_pull_o,
    input logic       scl_sync,
    input logic       start_evt,
    input logic       stop_evt,
    input tgt_state_t state,
    input logic [2:0] bit_cnt
);

    // R11
    pull_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_sync);

    // R9
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == ST_ADDR && bit_cnt == 3'd0));

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!sda_pull_o && state == ST_ADDR));

    // R7
    idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_ADDR || state == ST_IDX) |-> !sda_pull_o);

    // R6
    tail_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MACK || state == ST_WAIT) |-> !sda_pull_o);

endmodule

bind i2c_regfile_target i2c_regfile_target_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_pull_o (sda_pull_o),
    .scl_sync   (scl_sync),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .state      (state),
    .bit_cnt    (bit_cnt)
);

// File: tb/i2c_regfile_target_tb.sv
// Bench: one master model and two targets on a wired-AND SDA line.
module i2c_regfile_target_tb;

    localparam logic [6:0] ADDR_A = 7'h2A;
    localparam logic [6:0] ADDR_B = 7'h51;
    localparam int NREG   = 16;
    localparam int STEP   = 37;
    localparam int SEED_A = 90;
    localparam int SEED_B = 201;
    localparam int Q      = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic pull_a;
    logic pull_b;
    wire  sda_bus = sda_m & ~pull_a & ~pull_b;

    int checks = 0;
    int fails = 0;
    int contention = 0;
    int edge_viol = 0;
    bit done = 1'b0;
    int cyc = 0;
    logic pa_q = 1'b0;
    logic pb_q = 1'b0;

    always #2 clk = ~clk;

    i2c_regfile_target #(.TGT_ADDR(ADDR_A), .NUM_REGS(NREG), .REG_STEP(STEP),
                         .REG_SEED(SEED_A)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_pull_o(pull_a));

    i2c_regfile_target #(.TGT_ADDR(ADDR_B), .NUM_REGS(NREG), .REG_STEP(STEP),
                         .REG_SEED(SEED_B)) u_dut2 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_pull_o(pull_b));

    // Bus monitors: contention (R8) and pull changes while SCL high (R11).
    always @(posedge clk) begin
        if (rst_n) begin
            if (pull_a && pull_b) contention++;
            if ((pull_a != pa_q || pull_b != pb_q) && scl) edge_viol++;
        end
        pa_q <= pull_a;
        pb_q <= pull_b;
    end

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
            summary();
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(2 * Q);
    endtask

    task automatic m_wbit(logic b);
        sda_m = b; wq(Q); scl = 1'b1; wq(2 * Q); scl = 1'b0; wq(Q);
    endtask

    task automatic m_rbit(output logic b);
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = sda_bus; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic m_wbyte(logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) m_wbit(v[i]);
        m_rbit(ack);
    endtask

    task automatic m_rbyte(logic mack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) m_rbit(v[i]);
        m_wbit(mack);
    endtask

    function automatic int exp_byte(int seed, int idx);
        return ((idx % NREG) * STEP + seed) % 256;
    endfunction

    // Full read: address, index, data, master ack bit, stop.
    task automatic read_tx(logic [6:0] a, logic rw, logic [7:0] idx, logic mack,
                           output logic ack_a, output logic ack_i,
                           output logic [7:0] d);
        m_start();
        m_wbyte({a, rw}, ack_a);
        m_wbyte(idx, ack_i);
        m_rbyte(mack, d);
        m_stop();
    endtask

    initial begin
        logic aa, ai, b;
        logic [7:0] d;
        wq(5);
        // R1: released during reset.
        check("R1 pull_a in reset", int'(pull_a), 0);
        check("R1 pull_b in reset", int'(pull_b), 0);
        rst_n = 1'b1;
        wq(10);
        check("R1 pull_a after reset", int'(pull_a), 0);
        check("R1 bus idle after reset", int'(sda_bus), 1);

        // R2/R7/R8: address sweep; only the two configured addresses ack.
        for (int a = 0; a < 128; a++) begin
            m_start();
            m_wbyte({7'(a), 1'b0}, aa);
            m_stop();
            check("R2 R8 address ack", int'(aa),
                  (a == int'(ADDR_A) || a == int'(ADDR_B)) ? 0 : 1);
        end

        // R4/R5/R3: sweep indices on target A (wrap past NREG), both rw values.
        for (int i = 0; i < 32; i++) begin
            read_tx(ADDR_A, 1'(i), 8'(i * 9 + (i / 16)), 1'(i >> 1), aa, ai, d);
            check("R3 ack with rw", int'(aa), 0);
            check("R4 index ack", int'(ai), 0);
            check("R5 data A", int'(d), exp_byte(SEED_A, i * 9 + (i / 16)));
        end

        // R5/R8: target B over all registers.
        for (int i = 0; i < NREG; i++) begin
            read_tx(ADDR_B, 1'b0, 8'(i), 1'b0, aa, ai, d);
            check("R8 ack B", int'(aa), 0);
            check("R5 data B", int'(d), exp_byte(SEED_B, i));
        end

        // R7: full transaction to an absent address reads all ones.
        for (int k = 0; k < 4; k++) begin
            read_tx(7'(8'h10 + k * 31), 1'b0, 8'h00, 1'b0, aa, ai, d);
            check("R7 mismatch addr ack", int'(aa), 1);
            check("R7 mismatch idx ack", int'(ai), 1);
            check("R7 mismatch data", int'(d), 8'hFF);
        end

        // R6: extra clocks after the data byte see SDA released.
        m_start();
        m_wbyte({ADDR_A, 1'b0}, aa);
        m_wbyte(8'd3, ai);
        m_rbyte(1'b1, d);
        check("R6 data before tail", int'(d), exp_byte(SEED_A, 3));
        for (int k = 0; k < 9; k++) begin
            m_rbit(b);
            check("R6 released after data", int'(b), 1);
        end
        m_stop();

        // R10: stop after three index bits, then a normal read.
        m_start();
        m_wbyte({ADDR_A, 1'b0}, aa);
        m_wbit(1'b1); m_wbit(1'b0); m_wbit(1'b1);
        m_stop();
        check("R10 released after stop", int'(sda_bus), 1);
        read_tx(ADDR_A, 1'b0, 8'd7, 1'b0, aa, ai, d);
        check("R10 data after stop", int'(d), exp_byte(SEED_A, 7));

        // R9: repeated start after address ack, then a fresh transaction.
        m_start();
        m_wbyte({ADDR_B, 1'b0}, aa);
        m_wbit(1'b0); m_wbit(1'b1);
        m_start();
        m_wbyte({ADDR_A, 1'b1}, aa);
        m_wbyte(8'd12, ai);
        m_rbyte(1'b1, d);
        m_stop();
        check("R9 ack after restart", int'(aa), 0);
        check("R9 data after restart", int'(d), exp_byte(SEED_A, 12));

        // R9: repeated start in the middle of the data byte.
        m_start();
        m_wbyte({ADDR_A, 1'b0}, aa);
        m_wbyte(8'd0, ai);
        m_rbit(b); m_rbit(b); m_rbit(b); m_rbit(b);
        wq(Q);
        m_start();
        m_wbyte({ADDR_B, 1'b0}, aa);
        m_wbyte(8'd5, ai);
        m_rbyte(1'b0, d);
        m_stop();
        check("R9 mid-data restart", int'(d), exp_byte(SEED_B, 5));

        check("R8 no contention", contention, 0);
        check("R11 pull changes while SCL low", edge_viol, 0);

        done = 1'b1;
        summary();
    end

endmodule